// File: doc/BRIEF.md
# Precise-Exception Reorder Buffer

This block sits between instruction issue and the architectural register file of a pipelined core. Each instruction that issues claims one slot at the tail of a circular buffer and receives that slot's index as a tag. Execution units finish in any order and send their result, together with a fault flag, back through a tagged writeback port. The block then makes those results permanent strictly in program order. The oldest slot leaves the buffer only after its result has arrived.

A clean oldest entry writes its destination register, or writes nothing if it is a store placeholder. A faulting oldest entry stops everything. No further register writes happen, issue is refused, every younger entry is thrown away, and the instruction address saved with the faulting entry is presented so that a handler can resume from an exact point. A flush input brings the buffer back to an empty, unfrozen state with the tags counting again from zero.

Top module: `prex_rob`

## Requirements
- R1: After reset or flush the first accepted issue gets tag 0. Each further accepted issue gets the next tag, counting modulo the depth (default 8). `iss_tag` always shows the tag that the next accepted issue will receive.
- R2: `iss_ready` is 0 while 8 entries are outstanding, while the block is frozen, and while the oldest entry holds a completed fault. An issue request made while it is 0 is not accepted.
- R3: A writeback sets the result, the fault flag and the done state of the live entry that its tag names, in any order. A writeback whose tag names no live entry has no effect.
- R4: Entries retire one per cycle, oldest first, and only once done. A clean non-store entry drives `rf_we`=1 with its destination and result in the cycle after its writeback edge, provided it is oldest then.
- R5: An issue with `iss_is_store`=1 occupies an entry and retires in order, but it never raises `rf_we`.
- R6: When the oldest entry is done with its fault flag set, `exc_valid` rises at the next edge and `exc_pc` holds that entry's issue PC. From then until a flush, `rf_we` stays 0 and `iss_ready` stays 0.
- R7: At the edge where a fault is taken, all younger entries are discarded. Later writebacks to their tags cause no register write.
- R8: `flush` empties the buffer, clears `exc_valid` and returns `iss_tag` to 0 in one edge. It has priority over a writeback or issue made in the same cycle.
- R9: Out of reset: `iss_ready`=1, `iss_tag`=0, `rf_we`=0, `exc_valid`=0.
- R10: With the buffer not full, an issue and a retirement may both occur at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the buffer and leave the frozen state |
| iss_valid | input | 1 | Issue request |
| iss_is_store | input | 1 | Issuing instruction is a store (no register write) |
| iss_dst | input | 5 | Destination register index |
| iss_pc | input | 32 | Instruction address of the issuing instruction |
| iss_ready | output | 1 | Issue will be accepted this cycle |
| iss_tag | output | 3 | Tag given to the next accepted issue |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | 3 | Entry addressed by the writeback |
| wb_data | input | 32 | Result value |
| wb_exc | input | 1 | Instruction faulted |
| rf_we | output | 1 | Register file write enable (retire this cycle) |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| exc_valid | output | 1 | Frozen on a precise fault |
| exc_pc | output | 32 | Address of the faulting instruction |

## Verification
The interesting collisions are an issue and a retirement on the same edge, and a flush landing together with a writeback. The first is provoked by filling all eight slots and then completing the oldest entry while issue requests are held high. In the cycle after the first retirement, `iss_ready` and `rf_we` are both high, and the reference model requires both the new slot and the retired register write. The second is provoked by pulsing `flush` with a writeback to a live tag. Every cycle is compared against a queue-based model in which the flush wins, so no register write may follow.

// File: rtl/prex_rob_pkg.sv
package prex_rob_pkg;

    parameter int ROB_DEPTH = 8;
    parameter int XLEN      = 32;
    parameter int PC_W      = 32;
    parameter int REG_AW    = 5;

    localparam int TAG_W = $clog2(ROB_DEPTH);
    localparam int PTR_W = TAG_W + 1;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [XLEN-1:0]   word_t;
    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [REG_AW-1:0] reg_t;

    typedef struct packed {
        logic  valid;
        logic  done;
        logic  fault;
        logic  is_store;
        reg_t  dst;
        pc_t   pc;
        word_t data;
    } rob_entry_t;

    typedef enum logic [1:0] {
        RET_IDLE  = 2'd0,
        RET_WRITE = 2'd1,
        RET_STORE = 2'd2,
        RET_FAULT = 2'd3
    } ret_kind_e;

    function automatic tag_t ptr_slot(input ptr_t p);
        return p[TAG_W-1:0];
    endfunction

    function automatic logic ptrs_full(input ptr_t h, input ptr_t t);
        return (h[TAG_W] != t[TAG_W]) && (h[TAG_W-1:0] == t[TAG_W-1:0]);
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs
    import prex_rob_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic alloc,
    input  logic pop,
    input  logic discard,
    output ptr_t head,
    output ptr_t tail,
    output logic full,
    output logic empty
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head <= '0;
            tail <= '0;
        end else if (discard) begin
            tail <= head;
        end else begin
            if (pop)   head <= head + 1'b1;
            if (alloc) tail <= tail + 1'b1;
        end
    end

    assign full  = ptrs_full(head, tail);
    assign empty = (head == tail);
endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import prex_rob_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_all,
    input  logic       alloc,
    input  tag_t       alloc_slot,
    input  logic       alloc_store,
    input  reg_t       alloc_dst,
    input  pc_t        alloc_pc,
    input  logic       pop,
    input  tag_t       head_slot,
    input  logic       wb_valid,
    input  tag_t       wb_tag,
    input  word_t      wb_data,
    input  logic       wb_exc,
    output rob_entry_t head_ent
);
    rob_entry_t ents [ROB_DEPTH];

    for (genvar i = 0; i < ROB_DEPTH; i++) begin : g_slot
        rob_entry_t ent_q;
        logic       hit_wb;
        logic       hit_alloc;
        logic       hit_pop;

        assign hit_wb    = wb_valid && (wb_tag == tag_t'(i)) && ent_q.valid;
        assign hit_alloc = alloc && (alloc_slot == tag_t'(i));
        assign hit_pop   = pop && (head_slot == tag_t'(i));

        always_ff @(posedge clk) begin
            if (rst || clear_all) begin
                ent_q.valid <= 1'b0;
                ent_q.done  <= 1'b0;
            end else begin
                if (hit_pop) ent_q.valid <= 1'b0;
                if (hit_wb) begin
                    ent_q.done  <= 1'b1;
                    ent_q.fault <= wb_exc;
                    ent_q.data  <= wb_data;
                end
                if (hit_alloc) begin
                    ent_q.valid    <= 1'b1;
                    ent_q.done     <= 1'b0;
                    ent_q.fault    <= 1'b0;
                    ent_q.is_store <= alloc_store;
                    ent_q.dst      <= alloc_dst;
                    ent_q.pc       <= alloc_pc;
                    ent_q.data     <= '0;
                end
            end
        end

        assign ents[i] = ent_q;
    end

    assign head_ent = ents[head_slot];
endmodule

// File: rtl/rob_commit.sv
module rob_commit
    import prex_rob_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       empty,
    input  rob_entry_t head_ent,
    output ret_kind_e  kind,
    output logic       frozen,
    output pc_t        fault_pc
);
    always_comb begin
        kind = RET_IDLE;
        if (!frozen && !empty && head_ent.valid && head_ent.done) begin
            if (head_ent.fault)         kind = RET_FAULT;
            else if (head_ent.is_store) kind = RET_STORE;
            else                        kind = RET_WRITE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            frozen   <= 1'b0;
            fault_pc <= '0;
        end else if (kind == RET_FAULT) begin
            frozen   <= 1'b1;
            fault_pc <= head_ent.pc;
        end
    end
endmodule

// File: rtl/prex_rob.sv
module prex_rob
    import prex_rob_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              iss_valid,
    input  logic              iss_is_store,
    input  logic [REG_AW-1:0] iss_dst,
    input  logic [PC_W-1:0]   iss_pc,
    output logic              iss_ready,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [XLEN-1:0]   wb_data,
    input  logic              wb_exc,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              exc_valid,
    output logic [PC_W-1:0]   exc_pc
);
    ptr_t       head, tail;
    logic       full, empty;
    logic       alloc, pop, discard;
    rob_entry_t head_ent;
    ret_kind_e  kind;
    logic       frozen;
    pc_t        fault_pc;
    tag_t       head_slot;

    assign head_slot = ptr_slot(head);
    assign discard   = (kind == RET_FAULT);
    assign pop       = (kind == RET_WRITE) || (kind == RET_STORE);
    assign iss_ready = !full && !frozen && !discard;
    assign alloc     = iss_valid && iss_ready && !flush;
    assign iss_tag   = ptr_slot(tail);

    rob_ptrs u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .alloc   (alloc),
        .pop     (pop),
        .discard (discard),
        .head    (head),
        .tail    (tail),
        .full    (full),
        .empty   (empty)
    );

    rob_entries u_ents (
        .clk         (clk),
        .rst         (rst),
        .clear_all   (flush || discard),
        .alloc       (alloc),
        .alloc_slot  (ptr_slot(tail)),
        .alloc_store (iss_is_store),
        .alloc_dst   (iss_dst),
        .alloc_pc    (iss_pc),
        .pop         (pop),
        .head_slot   (head_slot),
        .wb_valid    (wb_valid),
        .wb_tag      (wb_tag),
        .wb_data     (wb_data),
        .wb_exc      (wb_exc),
        .head_ent    (head_ent)
    );

    rob_commit u_commit (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .empty    (empty),
        .head_ent (head_ent),
        .kind     (kind),
        .frozen   (frozen),
        .fault_pc (fault_pc)
    );

    assign rf_we     = (kind == RET_WRITE);
    assign rf_waddr  = head_ent.dst;
    assign rf_wdata  = head_ent.data;
    assign exc_valid = frozen;
    assign exc_pc    = fault_pc;

    // R6: no register write once frozen
    a_r6_no_write_frozen: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> !rf_we);

    // R6: fault state and address held until flush
    a_r6_fault_held: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !flush) |=> (exc_valid && $stable(exc_pc)));

    // R7: taking a fault leaves no live entry behind
    a_r7_discard_young: assert property (@(posedge clk) disable iff (rst)
        $rose(exc_valid) |-> empty);

    // R8: flush empties and unfreezes in one edge
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (empty && !exc_valid && iss_tag == '0));

    // R4: each register retirement advances the head by one slot
    a_r4_head_steps: assert property (@(posedge clk) disable iff (rst)
        (rf_we && !flush) |=> (head_slot == tag_t'($past(head_slot) + 1'b1)));

    // R1: an accepted issue advances the tag by one
    a_r1_tag_steps: assert property (@(posedge clk) disable iff (rst)
        (alloc && !flush) |=> (iss_tag == tag_t'($past(iss_tag) + 1'b1)));
endmodule

// File: tb/prex_rob_tb.sv
`timescale 1ns/1ps
module prex_rob_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        iss_valid = 1'b0, iss_is_store = 1'b0;
    logic [4:0]  iss_dst = '0;
    logic [31:0] iss_pc = '0;
    logic        iss_ready;
    logic [2:0]  iss_tag;
    logic        wb_valid = 1'b0, wb_exc = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [31:0] wb_data = '0;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        exc_valid;
    logic [31:0] exc_pc;

    always #4 clk = ~clk;

    prex_rob u_dut (
        .clk(clk), .rst(rst), .flush(flush),
        .iss_valid(iss_valid), .iss_is_store(iss_is_store), .iss_dst(iss_dst),
        .iss_pc(iss_pc), .iss_ready(iss_ready), .iss_tag(iss_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .exc_valid(exc_valid), .exc_pc(exc_pc)
    );

    typedef struct {
        int tag; int dst; int pc; bit st; bit done; int data; bit exc;
    } m_ent_t;

    m_ent_t m_q[$];
    int     next_tag = 0;
    bit     m_frozen = 0;
    int     m_epc = 0;
    int     errors = 0;
    int     checks = 0;
    string  cur_req = "R9";
    bit     both_seen = 0;
    int     writes_seen = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s) actual=%0h expected=%0h", what, cur_req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush = 0; iss_valid = 0; iss_is_store = 0; wb_valid = 0; wb_exc = 0;
    endtask

    task automatic tick();
        bit e_ready, e_we, h_ok;
        #1;
        h_ok    = !m_frozen && m_q.size() > 0 && m_q[0].done;
        e_ready = (m_q.size() < 8) && !m_frozen && !(h_ok && m_q[0].exc);
        e_we    = h_ok && !m_q[0].exc && !m_q[0].st;
        if (!rst) begin
            chk(iss_ready == e_ready, "R2 iss_ready", iss_ready, e_ready);
            chk(int'(iss_tag) == next_tag, "R1 iss_tag", iss_tag, next_tag);
            chk(rf_we == e_we, "R4 rf_we", rf_we, e_we);
            if (e_we && rf_we) begin
                chk(int'(rf_waddr) == m_q[0].dst, "R4 rf_waddr", rf_waddr, m_q[0].dst);
                chk(int'(rf_wdata) == m_q[0].data, "R4 rf_wdata", rf_wdata, m_q[0].data);
            end
            chk(exc_valid == m_frozen, "R6 exc_valid", exc_valid, m_frozen);
            if (m_frozen) chk(int'(exc_pc) == m_epc, "R6 exc_pc", exc_pc, m_epc);
            if (iss_ready && rf_we) both_seen = 1;
            if (rf_we) writes_seen++;
        end
        @(posedge clk);
        if (rst || flush) begin
            m_q.delete(); next_tag = 0; m_frozen = 0; m_epc = 0;
        end else begin
            if (h_ok) begin
                if (m_q[0].exc) begin
                    m_frozen = 1; m_epc = m_q[0].pc; next_tag = m_q[0].tag;
                    m_q.delete();
                end else begin
                    m_q.delete(0);
                end
            end
            if (wb_valid)
                foreach (m_q[i])
                    if (m_q[i].tag == int'(wb_tag)) begin
                        m_q[i].done = 1; m_q[i].data = wb_data; m_q[i].exc = wb_exc;
                    end
            if (iss_valid && e_ready) begin
                m_ent_t n;
                n.tag = next_tag; n.dst = iss_dst; n.pc = iss_pc; n.st = iss_is_store;
                n.done = 0; n.data = 0; n.exc = 0;
                m_q.push_back(n);
                next_tag = (next_tag + 1) % 8;
            end
        end
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic iss(input bit st, input int dst, input int pc);
        iss_valid = 1; iss_is_store = st; iss_dst = 5'(dst); iss_pc = 32'(pc);
    endtask

    task automatic wbk(input int tag, input int data, input bit exc);
        wb_valid = 1; wb_tag = 3'(tag); wb_data = 32'(data); wb_exc = exc;
    endtask

    task automatic drain();
        for (int g = 0; g < 40 && m_q.size() > 0; g++) begin
            foreach (m_q[i])
                if (!m_q[i].done) begin
                    wbk(m_q[i].tag, 32'h5000 + m_q[i].tag, 0);
                    break;
                end
            tick();
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int t0;
        @(negedge clk);
        rst = 1;
        tick(); tick(); tick();
        rst = 0;
        #1;
        // R9 reset values
        chk(iss_ready == 1, "R9 ready after reset", iss_ready, 1);
        chk(iss_tag == 0, "R9 tag after reset", iss_tag, 0);
        chk(rf_we == 0, "R9 no write after reset", rf_we, 0);
        chk(exc_valid == 0, "R9 no fault after reset", exc_valid, 0);

        // R1 R3 R4: out-of-order completion, in-order retirement
        cur_req = "R4";
        iss(0, 1, 'h100); tick();
        iss(0, 2, 'h104); tick();
        iss(0, 3, 'h108); tick();
        wbk(2, 'hC2, 0); tick();
        wbk(0, 'hA0, 0); tick();
        wbk(1, 'hB1, 0); tick();
        repeat (4) tick();

        // R3: writeback to a dead tag is ignored
        cur_req = "R3";
        writes_seen = 0;
        wbk(6, 'hDEAD, 0); tick();
        repeat (3) tick();
        chk(writes_seen == 0, "R3 stray writeback wrote", writes_seen, 0);

        // R2 R10: fill, then retire while issuing
        cur_req = "R2";
        for (int k = 0; k < 8; k++) begin iss(0, k + 4, 'h200 + 4 * k); tick(); end
        iss(0, 20, 'h300); tick();
        chk(m_q.size() == 8, "R2 ninth issue refused", m_q.size(), 8);
        cur_req = "R10";
        both_seen = 0;
        for (int k = 0; k < 8; k++) begin
            iss(0, 21, 'h400 + 4 * k);
            wbk(m_q[k].tag, 'h700 + k, 0);
            tick();
        end
        repeat (2) begin iss(0, 22, 'h480); tick(); end
        chk(both_seen, "R10 issue and retire same cycle", both_seen, 1);
        drain();

        // R5: stores retire without a register write
        cur_req = "R5";
        writes_seen = 0;
        t0 = next_tag;
        iss(1, 9, 'h500); tick();
        iss(1, 10, 'h504); tick();
        wbk(t0, 'h1, 0); tick();
        wbk((t0 + 1) % 8, 'h2, 0); tick();
        repeat (3) tick();
        chk(writes_seen == 0 && m_q.size() == 0, "R5 store wrote register", writes_seen, 0);

        // R6 R7: precise fault on the second entry
        cur_req = "R6";
        t0 = next_tag;
        for (int k = 0; k < 4; k++) begin iss(0, 11 + k, 'h600 + 4 * k); tick(); end
        wbk((t0 + 1) % 8, 'hF1, 1); tick();
        wbk((t0 + 3) % 8, 'hF3, 0); tick();
        wbk((t0 + 2) % 8, 'hF2, 0); tick();
        wbk(t0, 'hF0, 0); tick();
        repeat (3) tick();
        chk(exc_valid == 1, "R6 fault raised", exc_valid, 1);
        chk(exc_pc == 'h604, "R6 faulting pc", exc_pc, 'h604);
        cur_req = "R7";
        writes_seen = 0;
        wbk((t0 + 2) % 8, 'hE2, 0); tick();
        iss(0, 30, 'h700); tick();
        repeat (3) tick();
        chk(writes_seen == 0, "R7 discarded entry wrote", writes_seen, 0);

        // R8: flush restarts, flush beats writeback
        cur_req = "R8";
        flush = 1; tick();
        chk(iss_tag == 0 && exc_valid == 0, "R8 flush state", {exc_valid, iss_tag}, 0);
        iss(0, 5, 'h800); tick();
        iss(0, 6, 'h804); tick();
        writes_seen = 0;
        flush = 1; wbk(0, 'h99, 0); tick();
        repeat (3) tick();
        chk(writes_seen == 0, "R8 writeback during flush", writes_seen, 0);
        iss(0, 7, 'h900); tick();
        wbk(0, 'h77, 0); tick();
        repeat (2) tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule